// File: doc/BRIEF.md
# Colour Space Converter with Chroma Decimation

This block accepts a raster stream of 24-bit RGB pixels (8 bits each for red, green and blue) and turns each pixel into a luma value Y and two colour-difference values Cb and Cr. It uses signed fixed-point matrix arithmetic with 8 fractional bits, then rounds, adds the channel offset and clamps. The chroma is then thinned out according to a two-bit sampling mode. Each of the three planes goes out on its own buffer write port, made of a write enable, an address and a data byte, so that a downstream coder can work on each plane as a separate grey-scale image.

A small tracker follows the raster position. It has two states. In WAIT_FRAME it ignores all pixels. The transition START (a valid pixel with the frame marker) moves it to RUN. In RUN every valid pixel is accepted. The transition RESTART (a valid pixel with the frame marker while in RUN) stays in RUN and resets the column, the line and both address counters. For each accepted pixel the tracker decides whether its chroma is kept and which plane addresses it gets. That side information goes through a delay line as deep as the arithmetic pipeline, so each write leaves the block together with its data.

Top module: `pix_ycc_splitter`

## Requirements
- R1: Y equals floor((66*R + 129*G + 25*B + 128) / 256) + 16, written on the Y port for every accepted pixel.
- R2: Cb equals floor((-38*R - 74*G + 112*B + 128) / 256) + 128 and Cr equals floor((112*R - 94*G - 18*B + 128) / 256) + 128, each clamped to 0..255. R is bits 23:16 of the pixel word, G is bits 15:8 and B is bits 7:0.
- R3: Every write appears exactly 3 clock edges after the edge that samples its pixel. A cycle with pixel valid low produces no write.
- R4: Mode 0 (4:4:4) keeps chroma for every accepted pixel.
- R5: Mode 1 (4:2:2) keeps chroma on even columns. Mode 3 (4:1:1) keeps it on columns that are a multiple of 4. Mode 2 (4:2:0) keeps it on even columns of even lines. A pixel with the frame or line marker is column 0, the frame-marker pixel is on line 0, and each line marker advances the line by one.
- R6: Chroma is decimated by dropping samples. Cb and Cr are always written together, and a chroma write only happens in a cycle that also writes Y.
- R7: The Y address is 0 for the frame-marker pixel and rises by one for each accepted pixel. The chroma address, shared by Cb and Cr, is 0 at the frame marker and rises by one for each kept sample.
- R8: After reset, valid pixels are ignored until the first frame marker (WAIT_FRAME to RUN). A frame marker in RUN restarts positions and addresses.
- R9: During reset all write enables, addresses and data outputs are zero.
- R10: The mode is sampled with each pixel, so a change of mode in the middle of a line takes effect from the next pixel on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_rgb | input | 24 | Pixel, R in 23:16, G in 15:8, B in 7:0 |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a line |
| mode | input | 2 | Sampling mode: 0 4:4:4, 1 4:2:2, 2 4:2:0, 3 4:1:1 |
| y_we | output | 1 | Y plane write enable |
| y_addr | output | ADDR_W | Y plane address |
| y_data | output | 8 | Y sample |
| cb_we | output | 1 | Cb plane write enable |
| cb_addr | output | ADDR_W | Cb plane address |
| cb_data | output | 8 | Cb sample |
| cr_we | output | 1 | Cr plane write enable |
| cr_addr | output | ADDR_W | Cr plane address |
| cr_data | output | 8 | Cr sample |

## Verification
A frame restart can collide with the draining pipeline. The last pixels of one frame are still in flight, and their chroma writes with high addresses are still to come, when the next frame marker arrives and the address counters return to zero. The bench provokes this by sending frames back to back with no idle cycle and by cutting a frame short with a new marker. The scoreboard then expects the old high addresses to be followed in the very next cycle by address 0, with every item checked against its due cycle.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

    localparam int PIX_W  = 8;
    localparam int COEF_W = 10;
    localparam int FRAC   = 8;

    typedef enum logic [1:0] {
        SMP_444 = 2'd0,
        SMP_422 = 2'd1,
        SMP_420 = 2'd2,
        SMP_411 = 2'd3
    } smp_mode_e;

    typedef enum logic {
        ST_WAIT_FRAME = 1'b0,
        ST_RUN        = 1'b1
    } trk_state_e;

    // Signed matrix weights, scaled by 2**FRAC. Row 0 luma, row 1 blue diff, row 2 red diff.
    function automatic logic signed [COEF_W-1:0] mat_coef(input int row, input int col);
        logic signed [COEF_W-1:0] k;
        k = '0;
        case (row * 3 + col)
            0: k = 10'sd66;
            1: k = 10'sd129;
            2: k = 10'sd25;
            3: k = -10'sd38;
            4: k = -10'sd74;
            5: k = 10'sd112;
            6: k = 10'sd112;
            7: k = -10'sd94;
            8: k = -10'sd18;
            default: k = '0;
        endcase
        return k;
    endfunction

    function automatic int mat_offset(input int row);
        return (row == 0) ? 16 : 128;
    endfunction

endpackage

// File: rtl/ycc_matrix.sv
module ycc_matrix
    import ycc_pkg::*;
#(
    parameter int P_W = PIX_W,
    parameter int C_W = COEF_W,
    parameter int F_B = FRAC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3*P_W-1:0] rgb,
    output logic [P_W-1:0]   y_val,
    output logic [P_W-1:0]   cb_val,
    output logic [P_W-1:0]   cr_val
);
    localparam int PROD_W = P_W + 1 + C_W;
    localparam int SUM_W  = PROD_W + 2;
    localparam int HALF   = 1 << (F_B - 1);
    localparam int MAXV   = (1 << P_W) - 1;

    logic [P_W-1:0] chan [3];
    logic [P_W-1:0] res_q [3];

    assign chan[0] = rgb[3*P_W-1:2*P_W];
    assign chan[1] = rgb[2*P_W-1:P_W];
    assign chan[2] = rgb[P_W-1:0];

    for (genvar r = 0; r < 3; r++) begin : g_row
        localparam logic signed [C_W-1:0] K0 = mat_coef(r, 0);
        localparam logic signed [C_W-1:0] K1 = mat_coef(r, 1);
        localparam logic signed [C_W-1:0] K2 = mat_coef(r, 2);
        localparam int OFFS = mat_offset(r);

        logic signed [PROD_W-1:0] p0_q, p1_q, p2_q;
        logic signed [SUM_W-1:0]  sum_q;
        logic signed [SUM_W-1:0]  val_c;

        // stage 1: products
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                p0_q <= '0;
                p1_q <= '0;
                p2_q <= '0;
            end else begin
                p0_q <= PROD_W'($signed({1'b0, chan[0]})) * PROD_W'(K0);
                p1_q <= PROD_W'($signed({1'b0, chan[1]})) * PROD_W'(K1);
                p2_q <= PROD_W'($signed({1'b0, chan[2]})) * PROD_W'(K2);
            end
        end

        // stage 2: sum
        always_ff @(posedge clk) begin
            if (!rst_n) sum_q <= '0;
            else        sum_q <= SUM_W'(p0_q) + SUM_W'(p1_q) + SUM_W'(p2_q);
        end

        // stage 3: round, offset, clamp
        always_comb val_c = ((sum_q + SUM_W'(HALF)) >>> F_B) + SUM_W'(OFFS);

        always_ff @(posedge clk) begin
            if (!rst_n)                     res_q[r] <= '0;
            else if (val_c < 0)             res_q[r] <= '0;
            else if (val_c > SUM_W'(MAXV))  res_q[r] <= P_W'(MAXV);
            else                            res_q[r] <= val_c[P_W-1:0];
        end
    end

    assign y_val  = res_q[0];
    assign cb_val = res_q[1];
    assign cr_val = res_q[2];

endmodule

// File: rtl/ycc_sampler.sv
module ycc_sampler
    import ycc_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int LINE_W = 10,
    parameter int ADDR_W = 12,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_sol,
    input  logic [1:0]        mode,
    output logic              y_we,
    output logic              c_we,
    output logic [ADDR_W-1:0] y_addr,
    output logic [ADDR_W-1:0] c_addr
);
    localparam int SB_W = 2 + 2 * ADDR_W;

    trk_state_e state_q, state_d;

    logic [COL_W-1:0]  col_next_q, col_c;
    logic [LINE_W-1:0] line_q, line_c;
    logic [ADDR_W-1:0] ya_next_q, ca_next_q, ya_c, ca_c;
    logic              take_c, keep_c, ctake_c;
    logic [SB_W-1:0]   sb_q [LAT];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_FRAME: if (in_valid && in_sof) state_d = ST_RUN;
            ST_RUN:        state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT_FRAME;
        else        state_q <= state_d;
    end

    // per-pixel decisions
    always_comb begin
        take_c = in_valid && (state_q == ST_RUN || in_sof);
        if (in_sof) begin
            col_c  = '0;
            line_c = '0;
        end else if (in_sol) begin
            col_c  = '0;
            line_c = line_q + LINE_W'(1);
        end else begin
            col_c  = col_next_q;
            line_c = line_q;
        end
        unique case (smp_mode_e'(mode))
            SMP_444: keep_c = 1'b1;
            SMP_422: keep_c = ~col_c[0];
            SMP_420: keep_c = ~col_c[0] & ~line_c[0];
            SMP_411: keep_c = (col_c[1:0] == 2'b00);
        endcase
        ctake_c = take_c && keep_c;
        ya_c    = in_sof ? '0 : ya_next_q;
        ca_c    = in_sof ? '0 : ca_next_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_next_q <= '0;
            line_q     <= '0;
            ya_next_q  <= '0;
            ca_next_q  <= '0;
        end else if (take_c) begin
            col_next_q <= col_c + COL_W'(1);
            line_q     <= line_c;
            ya_next_q  <= ya_c + ADDR_W'(1);
            if (ctake_c) ca_next_q <= ca_c + ADDR_W'(1);
        end
    end

    // side-band delay matched to the arithmetic pipeline
    for (genvar i = 0; i < LAT; i++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n)      sb_q[i] <= '0;
            else if (i == 0) sb_q[i] <= {take_c, ctake_c, ya_c, ca_c};
            else             sb_q[i] <= sb_q[(i == 0) ? 0 : i - 1];
        end
    end

    assign {y_we, c_we, y_addr, c_addr} = sb_q[LAT-1];

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (y_we && $past(y_we) && y_addr != '0) |-> (y_addr == $past(y_addr) + ADDR_W'(1))); // R7

endmodule

// File: rtl/pix_ycc_splitter.sv
module pix_ycc_splitter
    import ycc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 10,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [23:0]       in_rgb,
    input  logic              in_sof,
    input  logic              in_sol,
    input  logic [1:0]        mode,
    output logic              y_we,
    output logic [ADDR_W-1:0] y_addr,
    output logic [7:0]        y_data,
    output logic              cb_we,
    output logic [ADDR_W-1:0] cb_addr,
    output logic [7:0]        cb_data,
    output logic              cr_we,
    output logic [ADDR_W-1:0] cr_addr,
    output logic [7:0]        cr_data
);
    localparam int PIPE_LAT = 3;

    logic              c_we;
    logic [ADDR_W-1:0] c_addr;

    ycc_matrix #(.P_W(PIX_W), .C_W(COEF_W), .F_B(FRAC)) u_matrix (
        .clk    (clk),
        .rst_n  (rst_n),
        .rgb    (in_rgb),
        .y_val  (y_data),
        .cb_val (cb_data),
        .cr_val (cr_data)
    );

    ycc_sampler #(.COL_W(COL_W), .LINE_W(LINE_W), .ADDR_W(ADDR_W), .LAT(PIPE_LAT)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_sol   (in_sol),
        .mode     (mode),
        .y_we     (y_we),
        .c_we     (c_we),
        .y_addr   (y_addr),
        .c_addr   (c_addr)
    );

    assign cb_we   = c_we;
    assign cr_we   = c_we;
    assign cb_addr = c_addr;
    assign cr_addr = c_addr;

    AST_CHROMA_WITH_Y: assert property (@(posedge clk) disable iff (!rst_n)
        cb_we |-> y_we); // R6
    AST_WRITE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        y_we |-> $past(in_valid, 3)); // R3
    AST_LUMA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        y_we |-> (y_data >= 8'd16 && y_data <= 8'd235)); // R1
    AST_FULL_CHROMA: assert property (@(posedge clk) disable iff (!rst_n)
        (y_we && $past(mode, 3) == SMP_444) |-> cb_we); // R4

endmodule

// File: tb/pix_ycc_splitter_tb.sv
module pix_ycc_splitter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;

    typedef struct {
        int    due;
        int    addr;
        int    d0;
        int    d1;
        string req;
    } exp_t;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          in_valid = 0;
    logic [23:0]   in_rgb = '0;
    logic          in_sof = 0;
    logic          in_sol = 0;
    logic [1:0]    mode = '0;
    logic          y_we, cb_we, cr_we;
    logic [AW-1:0] y_addr, cb_addr, cr_addr;
    logic [7:0]    y_data, cb_data, cr_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    exp_t yq[$];
    exp_t cq[$];

    // bench model of the raster position
    bit m_run = 0;
    int m_col = 0, m_line = 0, m_ynext = 0, m_cnext = 0;

    pix_ycc_splitter #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rgb(in_rgb),
        .in_sof(in_sof), .in_sol(in_sol), .mode(mode),
        .y_we(y_we), .y_addr(y_addr), .y_data(y_data),
        .cb_we(cb_we), .cb_addr(cb_addr), .cb_data(cb_data),
        .cr_we(cr_we), .cr_addr(cr_addr), .cr_data(cr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int conv(input int a, input int b, input int c,
                                input int r, input int g, input int bl, input int off);
        int s;
        s = a * r + b * g + c * bl + 128;
        s = (s >>> 8) + off;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return s;
    endfunction

    // driver: presents one pixel and pushes expected writes
    task automatic send(input int r, input int g, input int b, input bit sof, input bit sol,
                        input int md, input int gap);
        exp_t e;
        bit   take, keep;
        int   col, line, ya, ca;
        @(negedge clk);
        in_valid = 1; in_rgb = {r[7:0], g[7:0], b[7:0]};
        in_sof = sof; in_sol = sol; mode = md[1:0];
        take = sof || m_run;
        if (take) begin
            if (sof) begin col = 0; line = 0; end
            else if (sol) begin col = 0; line = m_line + 1; end
            else begin col = m_col; line = m_line; end
            case (md)
                0: keep = 1;
                1: keep = (col % 2) == 0;
                2: keep = (col % 2) == 0 && (line % 2) == 0;
                default: keep = (col % 4) == 0;
            endcase
            ya = sof ? 0 : m_ynext;
            ca = sof ? 0 : m_cnext;
            m_run = 1; m_col = col + 1; m_line = line; m_ynext = ya + 1;
            e.due = cyc + 3; e.addr = ya % (1 << AW);
            e.d0 = conv(66, 129, 25, r, g, b, 16); e.d1 = 0; e.req = "R1";
            yq.push_back(e);
            if (keep) begin
                m_cnext = ca + 1;
                e.addr = ca % (1 << AW);
                e.d0 = conv(-38, -74, 112, r, g, b, 128);
                e.d1 = conv(112, -94, -18, r, g, b, 128);
                e.req = (md == 0) ? "R4" : "R5";
                cq.push_back(e);
            end
        end
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            in_valid = 0; in_sof = 0; in_sol = 0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0; in_sof = 0; in_sol = 0; in_rgb = '0;
        end
    endtask

    task automatic frame(input int w, input int h, input int md, input int seed, input int gap);
        int r, g, b;
        for (int ln = 0; ln < h; ln++) begin
            for (int c = 0; c < w; c++) begin
                r = (seed + 37 * c + 91 * ln) % 256;
                g = (seed * 3 + 53 * c + 17 * ln) % 256;
                b = (seed * 7 + 29 * c + 71 * ln) % 256;
                send(r, g, b, ln == 0 && c == 0, ln != 0 && c == 0, md, gap);
            end
        end
    endtask

    // monitor: pops and compares
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (y_we) begin
                if (yq.size() == 0) check(0, "R8", "unexpected Y write addr", int'(y_addr), -1);
                else begin
                    e = yq.pop_front();
                    check(e.due == cyc, "R3", "Y write cycle", cyc, e.due);
                    check(int'(y_addr) == e.addr, "R7", "Y addr", int'(y_addr), e.addr);
                    check(int'(y_data) == e.d0, e.req, "Y data", int'(y_data), e.d0);
                end
            end else if (yq.size() > 0 && yq[0].due <= cyc) begin
                e = yq.pop_front();
                check(0, "R3", "missing Y write due", cyc, e.due);
            end
            check(cb_we == cr_we, "R6", "cb_we vs cr_we", int'(cb_we), int'(cr_we));
            if (cb_we) begin
                check(y_we, "R6", "chroma without Y", int'(y_we), 1);
                if (cq.size() == 0) check(0, "R5", "unexpected chroma write addr", int'(cb_addr), -1);
                else begin
                    e = cq.pop_front();
                    check(e.due == cyc, "R3", "chroma write cycle", cyc, e.due);
                    check(int'(cb_addr) == e.addr, "R7", "Cb addr", int'(cb_addr), e.addr);
                    check(int'(cr_addr) == e.addr, "R7", "Cr addr", int'(cr_addr), e.addr);
                    check(int'(cb_data) == e.d0, "R2", "Cb data", int'(cb_data), e.d0);
                    check(int'(cr_data) == e.d1, "R2", "Cr data", int'(cr_data), e.d1);
                end
            end else if (cq.size() > 0 && cq[0].due <= cyc) begin
                e = cq.pop_front();
                check(0, e.req, "missing chroma write due", cyc, e.due);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R9: reset state, with inputs active to show they have no effect
        in_valid = 1; in_sof = 1; in_rgb = 24'hFFFFFF;
        repeat (5) @(negedge clk);
        check({y_we, cb_we, cr_we} == 3'b000, "R9", "enables in reset", int'({y_we, cb_we, cr_we}), 0);
        check(y_addr == 0 && cb_addr == 0 && cr_addr == 0, "R9", "addresses in reset", int'(y_addr), 0);
        check(y_data == 0 && cb_data == 0 && cr_data == 0, "R9", "data in reset", int'(y_data), 0);
        in_valid = 0; in_sof = 0;
        @(negedge clk);
        rst_n = 1;
        idle(2);
        // R8: pixels before the first frame marker are ignored
        send(200, 10, 10, 0, 0, 0, 0);
        send(10, 200, 10, 0, 1, 0, 0);
        send(10, 10, 200, 0, 0, 0, 1);
        idle(5);
        check(yq.size() == 0, "R8", "pending writes before frame start", yq.size(), 0);
        // R1 R2 R4: extreme colours in 4:4:4, with gaps
        send(255, 255, 255, 1, 0, 0, 1);
        send(0, 0, 0, 0, 0, 0, 0);
        send(255, 0, 0, 0, 0, 0, 2);
        send(0, 255, 0, 0, 0, 0, 0);
        send(0, 0, 255, 0, 0, 0, 0);
        send(255, 255, 0, 0, 1, 0, 0);
        send(0, 255, 255, 0, 0, 0, 0);
        idle(6);
        frame(6, 3, 0, 5, 1);
        // R5: each decimating mode, frames back to back without idle
        frame(8, 2, 1, 40, 0);
        frame(8, 4, 2, 77, 0);
        frame(9, 3, 3, 123, 0);
        // R8 R7: frame cut short by a new marker
        frame(7, 2, 2, 9, 0);
        send(1, 2, 3, 0, 1, 2, 0);
        send(4, 5, 6, 0, 0, 2, 0);
        frame(5, 2, 3, 201, 0);
        // R10: mode changes in the middle of a line
        send(90, 30, 60, 1, 0, 0, 0);
        send(91, 31, 61, 0, 0, 0, 0);
        send(92, 32, 62, 0, 0, 3, 0);
        send(93, 33, 63, 0, 0, 3, 0);
        send(94, 34, 64, 0, 0, 1, 0);
        send(95, 35, 65, 0, 0, 1, 0);
        send(96, 36, 66, 0, 1, 2, 0);
        send(97, 37, 67, 0, 0, 0, 0);
        idle(8);
        check(yq.size() == 0, "R3", "Y items left", yq.size(), 0);
        check(cq.size() == 0, "R6", "chroma items left", cq.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule